// File: doc/BRIEF.md
# Page write load controller

This block is a clocked behavioural model of the write path of a byte-wide, page-organised nonvolatile memory. The host drives active-low chip select, output enable and write strobe lines, an address and a data byte. Every write pulse adds one byte to an internal page buffer. All bytes of one load session must share the same page number, which is taken from the upper address bits. The lower seven bits select the byte within the 128-byte page.

When no new byte arrives within a set number of clock cycles after the previous one, loading closes. A self-timed programming interval then starts and `busy` is high for its whole length. At the end of that interval only the bytes that were actually loaded are copied into the storage array. The other bytes of the page keep their old values. A separate registered read port returns the contents of the storage array. Both the load window and the programming time are parameters given in clock cycles.

Top module: `page_load_engine`

## Requirements
- R1: After reset `busy` and `page_miss` are 0, and every storage byte reads back as 8'hFF.
- R2: A write pulse is the interval in which `cs_n` and `we_n` are both low. It starts at the later of the two falling strobes and ends at the earlier of the two rising strobes. A pulse led by the write strobe and a pulse led by chip select store the same way.
- R3: A pulse is inhibited when `oe_n` is low at its start or at its end. It then loads nothing: `busy` does not rise and storage is unchanged.
- R4: The address is sampled in the cycle in which the pulse starts. The data is sampled in the cycle in which it ends. Address changes inside the pulse have no effect, and the data value present at the end of the pulse is the one stored.
- R5: Programming starts (`busy` rises) exactly WIN_CYC clock cycles after the edge that loaded the last byte. Each new load inside the window restarts that count.
- R6: Address bits [ADDR_W-1:7] are the page number. The first load of a session fixes the page. A later load to a different page is dropped, and `page_miss` is high for exactly one cycle in the cycle after the drop.
- R7: Bytes of a page may be loaded in any order. A byte loaded twice in one session stores the value of its last load.
- R8: Only the bytes loaded in the session are written at commit. The other bytes of that page keep their previous values.
- R9: `busy` stays high for exactly PROG_CYC cycles. Write pulses that start while `busy` is high are ignored and do not open a new session.
- R10: All 128 bytes of a page can be loaded in one session and are committed together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low; low inhibits writes |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W (10) | Write address; bits [6:0] give the byte in the page, upper bits give the page |
| wdata | input | 8 | Write data byte |
| rd_addr | input | ADDR_W (10) | Read address |
| rd_data | output | 8 | Storage byte at `rd_addr`, valid one cycle later |
| busy | output | 1 | High while the programming interval runs |
| page_miss | output | 1 | One-cycle pulse when a load to a foreign page is dropped |

## Verification
A wrong window or programming counter shows up as a `busy` edge that lands a cycle or more away from its expected time. The bench counts that time exactly, so one cycle of drift is seen within the same write. A byte-valid mask that is wrong, or is not cleared, corrupts neighbouring bytes or a later page. This becomes visible on the read port at the first read after that commit. A page tag that is not held would let foreign bytes through, which then read back as written in place of 8'hFF once `busy` falls. It would also make the `page_miss` pulse go missing in the cycle after the dropped load.

// File: rtl/pgld_pkg.sv
package pgld_pkg;

    localparam int BYTE_W   = 8;
    localparam int PG_OFF_W = 7;
    localparam int PG_BYTES = 1 << PG_OFF_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PROG
    } wr_state_e;

    typedef struct packed {
        logic [PG_OFF_W-1:0] off;
        logic [BYTE_W-1:0]   data;
    } byte_ld_t;

    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pgld_strobe.sv
module pgld_strobe
    import pgld_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              blocked,
    output logic              ld_ev,
    output logic [ADDR_W-1:0] ld_addr,
    output logic [BYTE_W-1:0] ld_data
);

    logic              act;
    logic              act_q;
    logic              armed;
    logic              pulse_start;
    logic              pulse_stop;
    logic [ADDR_W-1:0] cap_addr;

    // pulse interval: both strobes low; start = later fall, stop = earlier rise
    assign act         = !cs_n && !we_n;
    assign pulse_start = act && !act_q;
    assign pulse_stop  = !act && act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= 1'b0;
            armed    <= 1'b0;
            cap_addr <= '0;
        end else begin
            act_q <= act;
            if (pulse_start) begin
                armed    <= oe_n && !blocked;
                cap_addr <= addr;
            end else if (pulse_stop) begin
                armed <= 1'b0;
            end
        end
    end

    assign ld_ev   = pulse_stop && armed && oe_n;
    assign ld_addr = cap_addr;
    assign ld_data = wdata;

endmodule

// File: rtl/pgld_ctrl.sv
module pgld_ctrl
    import pgld_pkg::*;
#(
    parameter int PG_W     = 3,
    parameter int WIN_CYC  = 7500,
    parameter int PROG_CYC = 500000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_ev,
    input  logic [PG_W-1:0] ld_page,
    input  logic [PG_W-1:0] tag,
    output logic            load_en,
    output logic            set_tag,
    output logic            commit,
    output logic            busy,
    output logic            miss
);

    localparam int WIN_W  = cnt_w(WIN_CYC);
    localparam int PROG_W = cnt_w(PROG_CYC);
    localparam logic [WIN_W-1:0]  WIN_LAST  = WIN_W'(WIN_CYC - 1);
    localparam logic [PROG_W-1:0] PROG_LAST = PROG_W'(PROG_CYC - 1);

    wr_state_e         state;
    logic [WIN_W-1:0]  win_cnt;
    logic [PROG_W-1:0] prog_cnt;
    logic              drop;

    always_comb begin
        set_tag = ld_ev && (state == ST_IDLE);
        load_en = set_tag || (ld_ev && (state == ST_LOAD) && (ld_page == tag));
        drop    = ld_ev && (state == ST_LOAD) && (ld_page != tag);
        commit  = (state == ST_PROG) && (prog_cnt == PROG_LAST);
        busy    = (state == ST_PROG);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            win_cnt  <= '0;
            prog_cnt <= '0;
            miss     <= 1'b0;
        end else begin
            miss <= drop;
            unique case (state)
                ST_IDLE: begin
                    if (set_tag) begin
                        state   <= ST_LOAD;
                        win_cnt <= '0;
                    end
                end
                ST_LOAD: begin
                    if (load_en) begin
                        win_cnt <= '0;
                    end else if (win_cnt == WIN_LAST) begin
                        state    <= ST_PROG;
                        prog_cnt <= '0;
                    end else begin
                        win_cnt <= win_cnt + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (commit) begin
                        state <= ST_IDLE;
                    end else begin
                        prog_cnt <= prog_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: the load window counter never passes its limit
    assert_win_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD) |-> (win_cnt <= WIN_LAST));

    // R9: the programming interval is bounded by PROG_CYC
    assert_prog_bound_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PROG) |-> (prog_cnt <= PROG_LAST));

endmodule

// File: rtl/pgld_latch.sv
module pgld_latch
    import pgld_pkg::*;
#(
    parameter int PG_W = 3
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              load_en,
    input  logic                              set_tag,
    input  logic                              clear,
    input  byte_ld_t                          ld,
    input  logic [PG_W-1:0]                   ld_page,
    output logic [PG_W-1:0]                   tag,
    output logic [PG_BYTES-1:0][BYTE_W-1:0]   pg_data,
    output logic [PG_BYTES-1:0]               pg_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tag <= '0;
        end else if (set_tag) begin
            tag <= ld_page;
        end
    end

    for (genvar g = 0; g < PG_BYTES; g++) begin : g_lane
        logic hit;
        assign hit = load_en && (ld.off == PG_OFF_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                pg_data[g]  <= '0;
                pg_valid[g] <= 1'b0;
            end else begin
                if (hit) begin
                    pg_data[g] <= ld.data;
                end
                if (clear) begin
                    pg_valid[g] <= 1'b0;
                end else if (hit) begin
                    pg_valid[g] <= 1'b1;
                end
            end
        end
    end

    // R8: after a commit the loaded-byte mask starts empty
    assert_mask_clear_R8: assert property (@(posedge clk) disable iff (rst)
        clear |=> (pg_valid == '0));

endmodule

// File: rtl/pgld_store.sv
module pgld_store
    import pgld_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PG_W   = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            commit,
    input  logic [PG_W-1:0]                 tag,
    input  logic [PG_BYTES-1:0][BYTE_W-1:0] pg_data,
    input  logic [PG_BYTES-1:0]             pg_valid,
    input  logic [ADDR_W-1:0]               rd_addr,
    output logic [BYTE_W-1:0]               rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
            rd_data <= '1;
        end else begin
            if (commit) begin
                for (int i = 0; i < PG_BYTES; i++) begin
                    if (pg_valid[i]) begin
                        mem[{tag, PG_OFF_W'(i)}] <= pg_data[i];
                    end
                end
            end
            rd_data <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/page_load_engine.sv
module page_load_engine
    import pgld_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int WIN_CYC  = 7500,
    parameter int PROG_CYC = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              page_miss
);

    localparam int PG_W = ADDR_W - PG_OFF_W;

    logic                            ld_ev;
    logic [ADDR_W-1:0]               ld_addr;
    logic [BYTE_W-1:0]               ld_data;
    logic                            load_en;
    logic                            set_tag;
    logic                            commit;
    logic [PG_W-1:0]                 tag;
    logic [PG_BYTES-1:0][BYTE_W-1:0] pg_data;
    logic [PG_BYTES-1:0]             pg_valid;
    byte_ld_t                        ld;

    assign ld.off  = ld_addr[PG_OFF_W-1:0];
    assign ld.data = ld_data;

    pgld_strobe #(.ADDR_W(ADDR_W)) u_strobe (
        .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .blocked(busy),
        .ld_ev(ld_ev), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    pgld_ctrl #(.PG_W(PG_W), .WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)) u_ctrl (
        .clk(clk), .rst(rst), .ld_ev(ld_ev),
        .ld_page(ld_addr[ADDR_W-1:PG_OFF_W]), .tag(tag),
        .load_en(load_en), .set_tag(set_tag), .commit(commit),
        .busy(busy), .miss(page_miss)
    );

    pgld_latch #(.PG_W(PG_W)) u_latch (
        .clk(clk), .rst(rst), .load_en(load_en), .set_tag(set_tag),
        .clear(commit), .ld(ld), .ld_page(ld_addr[ADDR_W-1:PG_OFF_W]),
        .tag(tag), .pg_data(pg_data), .pg_valid(pg_valid)
    );

    pgld_store #(.ADDR_W(ADDR_W), .PG_W(PG_W)) u_store (
        .clk(clk), .rst(rst), .commit(commit), .tag(tag),
        .pg_data(pg_data), .pg_valid(pg_valid),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // R9: the commit cycle ends the programming interval
    assert_commit_ends_busy_R9: assert property (@(posedge clk) disable iff (rst)
        commit |=> !busy);

    // R6: a dropped-load flag lasts one cycle only
    assert_miss_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        page_miss |=> !page_miss);

    // R9: no byte enters the page buffer while programming runs
    assert_no_load_in_prog_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> !(ld_ev && $past(busy) && !set_tag && load_en));

endmodule

// File: tb/test_page_load_engine.sv
module test_page_load_engine;

    localparam int CLK_P = 10;
    localparam int AW    = 10;
    localparam int WIN   = 16;
    localparam int PROG  = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0, rd_addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rd_data;
    logic          busy, page_miss;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    page_load_engine #(.ADDR_W(AW), .WIN_CYC(WIN), .PROG_CYC(PROG)) i_page_load_engine (
        .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .page_miss(page_miss)
    );

    function automatic logic [AW-1:0] pa(input int page, input int off);
        return AW'((page << 7) | off);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one write pulse; returns at the falling edge after the load edge
    task automatic wr_byte(input logic [AW-1:0] a, input logic [7:0] d,
                           input bit ce_ctl, input bit oe_low,
                           input bit alter, input logic [AW-1:0] a2,
                           input logic [7:0] d2);
        @(negedge clk);
        addr = a; wdata = d; oe_n = !oe_low;
        if (ce_ctl) we_n = 1'b0; else cs_n = 1'b0;
        @(negedge clk);
        if (ce_ctl) cs_n = 1'b0; else we_n = 1'b0;
        @(negedge clk);
        if (alter) begin
            addr = a2; wdata = d2;
            @(negedge clk);
        end
        if (ce_ctl) cs_n = 1'b1; else we_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_byte(a, d, 1'b0, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic finish_write(input string req);
        int n = 0;
        while (!busy && n < 2000) begin @(negedge clk); n++; end
        chk({req, " busy rises"}, busy, 1);
        n = 0;
        while (busy && n < 2000) begin @(negedge clk); n++; end
        chk({req, " busy falls"}, busy, 0);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 busy after reset", busy, 0);
        chk("R1 page_miss after reset", page_miss, 0);
        rd(pa(0, 0), d);   chk("R1 erased byte 0", d, 8'hFF);
        rd(pa(7, 127), d); chk("R1 erased top byte", d, 8'hFF);
    endtask

    task automatic t_we_led();
        logic [7:0] d;
        int n, m;
        wr(pa(1, 37), 8'h3C);
        n = 1;
        forever begin @(negedge clk); if (busy || n > 1000) break; n++; end
        chk("R5 window length", n, WIN);
        m = 1;
        forever begin @(negedge clk); if (!busy || m > 1000) break; m++; end
        chk("R9 busy length", m, PROG);
        rd(pa(1, 37), d); chk("R2 write-strobe-led byte", d, 8'h3C);
        rd(pa(1, 38), d); chk("R8 neighbour kept", d, 8'hFF);
    endtask

    task automatic t_ce_led();
        logic [7:0] d;
        wr_byte(pa(2, 5), 8'hA7, 1'b1, 1'b0, 1'b0, '0, '0);
        finish_write("R2");
        rd(pa(2, 5), d); chk("R2 select-led byte", d, 8'hA7);
    endtask

    task automatic t_inhibit();
        logic [7:0] d;
        int seen = 0;
        wr_byte(pa(3, 9), 8'h11, 1'b0, 1'b1, 1'b0, '0, '0);
        for (int i = 0; i < WIN + 8; i++) begin
            @(negedge clk);
            if (busy) seen = 1;
        end
        chk("R3 no busy when oe low", seen, 0);
        rd(pa(3, 9), d); chk("R3 byte unchanged", d, 8'hFF);
    endtask

    task automatic t_capture();
        logic [7:0] d;
        wr_byte(pa(4, 20), 8'h01, 1'b0, 1'b0, 1'b1, pa(4, 21), 8'h9E);
        finish_write("R4");
        rd(pa(4, 20), d); chk("R4 address from start, data from end", d, 8'h9E);
        rd(pa(4, 21), d); chk("R4 late address ignored", d, 8'hFF);
    endtask

    task automatic t_order();
        logic [7:0] d;
        rd(pa(5, 64), d);
        wr(pa(5, 10), 8'h11);
        wr(pa(5, 2),  8'h22);
        wr(pa(5, 10), 8'h33);
        finish_write("R7");
        rd(pa(5, 10), d); chk("R7 last load wins", d, 8'h33);
        rd(pa(5, 2), d);  chk("R7 out of order byte", d, 8'h22);
        rd(pa(5, 5), d);  chk("R8 unloaded byte kept", d, 8'hFF);
    endtask

    task automatic t_miss();
        logic [7:0] d;
        wr(pa(6, 1), 8'h61);
        chk("R6 no flag on first load", page_miss, 0);
        wr(pa(0, 1), 8'h0F);
        chk("R6 flag after foreign load", page_miss, 1);
        @(negedge clk);
        chk("R6 flag one cycle", page_miss, 0);
        finish_write("R6");
        rd(pa(6, 1), d); chk("R6 own page written", d, 8'h61);
        rd(pa(0, 1), d); chk("R6 foreign byte dropped", d, 8'hFF);
    endtask

    task automatic t_full();
        logic [7:0] d;
        int bad = 0;
        for (int i = 0; i < 128; i++) wr(pa(7, i), 8'(i ^ 8'h5A));
        finish_write("R10");
        for (int i = 0; i < 128; i++) begin
            rd(pa(7, i), d);
            if (d != 8'(i ^ 8'h5A)) bad++;
        end
        chk("R10 full page mismatches", bad, 0);
    endtask

    task automatic t_blocked();
        logic [7:0] d;
        int n = 0;
        int seen = 0;
        wr(pa(3, 100), 8'hC3);
        while (!busy && n < 2000) begin @(negedge clk); n++; end
        wr(pa(3, 101), 8'hD4);
        n = 0;
        while (busy && n < 2000) begin @(negedge clk); n++; end
        for (int i = 0; i < WIN + 8; i++) begin
            @(negedge clk);
            if (busy) seen = 1;
        end
        chk("R9 no session from blocked pulse", seen, 0);
        rd(pa(3, 100), d); chk("R9 pre-busy byte stored", d, 8'hC3);
        rd(pa(3, 101), d); chk("R9 blocked byte dropped", d, 8'hFF);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_we_led();
        t_ce_led();
        t_inhibit();
        t_capture();
        t_order();
        t_miss();
        t_full();
        t_blocked();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule